// File: doc/BRIEF.md
# Transfer Byte Counter with Interrupt Status

This block keeps track of how far a data-phase transfer has progressed. Host software loads a byte count and a starting address through a byte-wide register port, then the transfer engine pulses `byte_done_i` once for every byte that has actually completed on the bus. Each accepted pulse takes one off the remaining count and adds one to the address. The address therefore always names the next byte to move, and it is the reliable pointer to use when the transfer stops early.

Three events are latched as status: the count has reached zero, the address has crossed a boundary of 2^CNT_W bytes, and a completion arrived when nothing was left to count. Software clears these bits by writing ones to the status offset. An enable byte selects which latched bits drive the single interrupt line.

Register map (byte offsets, with the defaults CNT_W=24 and ADDR_W=32): 0..2 hold the count, least significant byte first. 3..6 hold the address, least significant byte first. 7 is control: a write with bit 0 set clears the count, and a read returns zero. 8 reads status and takes a write-one-to-clear mask. 9 is the interrupt enable. Unused offsets read zero.

Top module: `xfer_count_stat`

## Requirements
- R1: After reset, every offset (count, address, control, status, enable) reads 0x00 and `irq_o` is low.
- R2: A write to count offsets 0, 1 or 2 replaces only that byte of the count, little-endian, and the byte reads back as written.
- R3: A `byte_done_i` pulse while the count is non-zero lowers the count by one and raises the address by one, visible on the next read.
- R4: When an accepted pulse takes the count from 1 to 0, status bit 0 (done) becomes set.
- R5: A `byte_done_i` pulse while the count is zero leaves both the count and the address unchanged, and sets status bit 2 (overrun).
- R6: Writing a byte with bit 0 set to offset 7 clears the count to zero without setting done, and offset 7 reads 0x00.
- R7: Writing to offset 8 clears each status bit whose data bit is 1. Status bits written with 0 keep their value.
- R8: `irq_o` is high exactly when some status bit and the enable bit at the same position at offset 9 are both 1.
- R9: Status bit 1 (wrap) becomes set when an accepted pulse carries the low CNT_W bits of the address from all ones to zero.
- R10: A pulse in the same cycle as a host write to any count, address or control offset is dropped. Only the write takes effect, and no status event is raised.
- R11: If a status event and a clear of the same bit fall in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host byte write strobe |
| addr_i | input | AW (4) | Host register offset for reads and writes |
| wdata_i | input | DW (8) | Host write data |
| rdata_o | output | DW (8) | Read data at `addr_i`, combinational |
| byte_done_i | input | 1 | One byte completed on the bus |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same cycle, and both are driven on purpose. In the first, a completion pulse meets a host write to an address byte. The bench then expects the count to keep its value and the address to hold exactly the written byte, with status unchanged. In the second, the pulse that empties the count coincides with a write that clears the done bit. There the bench expects done still set, and the count and address both moved by one.

// File: rtl/xcs_pkg.sv
package xcs_pkg;
  localparam int ST_DONE = 0;
  localparam int ST_WRAP = 1;
  localparam int ST_OVR  = 2;
  localparam int NUM_ST  = 3;
endpackage

// File: rtl/xcs_byte_cnt.sv
module xcs_byte_cnt #(
  parameter  int CNT_W = 24,
  parameter  int DW    = 8,
  localparam int NB    = CNT_W / DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NB-1:0]    lane_we_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             adv_o,
  output logic             done_o,
  output logic             ovr_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             host_busy, is_zero;

  assign host_busy = clr_i | (|lane_we_i);
  assign is_zero   = (cnt_q == '0);
  assign adv_o     = step_i & ~host_busy & ~is_zero;
  assign done_o    = adv_o & (cnt_q == CNT_W'(1));
  assign ovr_o     = step_i & ~host_busy & is_zero;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (|lane_we_i) begin
      for (int i = 0; i < NB; i++)
        if (lane_we_i[i]) cnt_q[i*DW +: DW] <= wdata_i;
    end else if (adv_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R3
  a_r3_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_o |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  // R5
  a_r5_hold_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && is_zero && !host_busy) |=> cnt_q == '0);
  // R6
  a_r6_clear_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  // R4
  a_r4_done_means_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> cnt_q == '0);
endmodule

// File: rtl/xcs_addr_cnt.sv
module xcs_addr_cnt #(
  parameter  int ADDR_W = 32,
  parameter  int CNT_W  = 24,
  parameter  int DW     = 8,
  localparam int NB     = ADDR_W / DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NB-1:0]     lane_we_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wrap_o
);
  logic [ADDR_W-1:0] addr_q;

  assign addr_o = addr_q;
  // low segment rolls over on this step
  assign wrap_o = adv_i & (&addr_q[CNT_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (|lane_we_i) begin
      for (int i = 0; i < NB; i++)
        if (lane_we_i[i]) addr_q[i*DW +: DW] <= wdata_i;
    end else if (adv_i) begin
      addr_q <= addr_q + ADDR_W'(1);
    end
  end

  // R3
  a_r3_addr_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !(|lane_we_i)) |=> addr_q == $past(addr_q) + ADDR_W'(1));
  // R9
  a_r9_wrap_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && !(|lane_we_i)) |=> addr_q[CNT_W-1:0] == '0);
endmodule

// File: rtl/xcs_irq_stat.sv
module xcs_irq_stat #(
  parameter int NS = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NS-1:0] ev_i,
  input  logic [NS-1:0] clr_i,
  input  logic          en_we_i,
  input  logic [NS-1:0] en_wdata_i,
  output logic [NS-1:0] stat_o,
  output logic [NS-1:0] en_o,
  output logic          irq_o
);
  logic [NS-1:0] stat_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_i) | ev_i;  // new event beats clear
      if (en_we_i) en_q <= en_wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign irq_o  = |(stat_q & en_q);

  // R11
  a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev_i) |=> (stat_q & $past(ev_i)) == $past(ev_i));
  // R7
  a_r7_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> (stat_q & $past(clr_i & ~ev_i)) == '0);
  // R7
  a_r7_zero_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (stat_q & $past(stat_q & ~clr_i)) == $past(stat_q & ~clr_i));
  // R8
  a_r8_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o);
endmodule

// File: rtl/xfer_count_stat.sv
module xfer_count_stat
  import xcs_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32,
  parameter int DW     = 8,
  parameter int AW     = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          byte_done_i,
  output logic          irq_o
);
  localparam int CNT_NB   = CNT_W / DW;
  localparam int ADDR_NB  = ADDR_W / DW;
  localparam int CNT_OFS  = 0;
  localparam int ADDR_OFS = CNT_OFS + CNT_NB;
  localparam int CTRL_OFS = ADDR_OFS + ADDR_NB;
  localparam int STAT_OFS = CTRL_OFS + 1;
  localparam int EN_OFS   = STAT_OFS + 1;

  logic [CNT_NB-1:0]  cnt_we;
  logic [ADDR_NB-1:0] addr_we;
  logic               blk, step, cnt_clr, adv, done_ev, ovr_ev, wrap_ev;
  logic [CNT_W-1:0]   cnt;
  logic [ADDR_W-1:0]  addr;
  logic [NUM_ST-1:0]  ev, stat_clr, stat, en;

  for (genvar g = 0; g < CNT_NB; g++) begin : g_cnt_we
    assign cnt_we[g] = wr_en_i && (addr_i == AW'(CNT_OFS + g));
  end
  for (genvar g = 0; g < ADDR_NB; g++) begin : g_addr_we
    assign addr_we[g] = wr_en_i && (addr_i == AW'(ADDR_OFS + g));
  end

  // host writes to counters or control drop a same-cycle strobe
  assign blk      = wr_en_i && (addr_i < AW'(STAT_OFS));
  assign step     = byte_done_i & ~blk;
  assign cnt_clr  = wr_en_i && (addr_i == AW'(CTRL_OFS)) && wdata_i[0];
  assign stat_clr = (wr_en_i && (addr_i == AW'(STAT_OFS))) ? wdata_i[NUM_ST-1:0] : '0;

  xcs_byte_cnt #(.CNT_W(CNT_W), .DW(DW)) u_cnt (
    .clk_i, .rst_ni,
    .lane_we_i (cnt_we),
    .wdata_i,
    .clr_i     (cnt_clr),
    .step_i    (step),
    .cnt_o     (cnt),
    .adv_o     (adv),
    .done_o    (done_ev),
    .ovr_o     (ovr_ev)
  );

  xcs_addr_cnt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DW(DW)) u_addr (
    .clk_i, .rst_ni,
    .lane_we_i (addr_we),
    .wdata_i,
    .adv_i     (adv),
    .addr_o    (addr),
    .wrap_o    (wrap_ev)
  );

  always_comb begin
    ev          = '0;
    ev[ST_DONE] = done_ev;
    ev[ST_WRAP] = wrap_ev;
    ev[ST_OVR]  = ovr_ev;
  end

  xcs_irq_stat #(.NS(NUM_ST)) u_stat (
    .clk_i, .rst_ni,
    .ev_i       (ev),
    .clr_i      (stat_clr),
    .en_we_i    (wr_en_i && (addr_i == AW'(EN_OFS))),
    .en_wdata_i (wdata_i[NUM_ST-1:0]),
    .stat_o     (stat),
    .en_o       (en),
    .irq_o
  );

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < CNT_NB; i++)
      if (addr_i == AW'(CNT_OFS + i)) rdata_o = cnt[i*DW +: DW];
    for (int i = 0; i < ADDR_NB; i++)
      if (addr_i == AW'(ADDR_OFS + i)) rdata_o = addr[i*DW +: DW];
    if (addr_i == AW'(STAT_OFS)) rdata_o = DW'(stat);
    if (addr_i == AW'(EN_OFS))   rdata_o = DW'(en);
  end

  // R10
  a_r10_write_drops_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done_i && blk) |=> $stable(stat));
  // R10
  a_r10_addr_not_stepped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done_i && blk && !(|addr_we)) |=> $stable(addr));
endmodule

// File: tb/xfer_count_stat_test.sv
module xfer_count_stat_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       byte_done_i = 1'b0;
  logic       irq_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct {bit is_irq; logic [3:0] a; logic [7:0] exp; string req;} item_t;
  item_t exp_q[$];
  event  chk_ev;

  always #2.5 clk_i = ~clk_i;

  xfer_count_stat uut (.*);

  // monitor: pops expected items and compares against the ports
  initial forever begin
    @(chk_ev);
    while (exp_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = exp_q.pop_front();
      act = it.is_irq ? {7'd0, irq_o} : rdata_o;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: offset %0d act=%02h exp=%02h", it.req, it.a, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input bit strobe = 0);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d; byte_done_i = strobe;
    @(negedge clk_i);
    wr_en_i = 1'b0; byte_done_i = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk_i);
    byte_done_i = 1'b1;
    @(negedge clk_i);
    byte_done_i = 1'b0;
  endtask

  task automatic expect_rd(input logic [3:0] a, input logic [7:0] e, input string req);
    item_t it;
    @(negedge clk_i);
    addr_i = a;
    #1;
    it = '{is_irq: 1'b0, a: a, exp: e, req: req};
    exp_q.push_back(it);
    ->chk_ev;
  endtask

  task automatic expect_irq(input bit e, input string req);
    item_t it;
    @(negedge clk_i);
    #1;
    it = '{is_irq: 1'b1, a: 4'hF, exp: {7'd0, e}, req: req};
    exp_q.push_back(it);
    ->chk_ev;
  endtask

  initial begin
    #(5ns * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    for (int i = 0; i < 10; i++) expect_rd(4'(i), 8'h00, "R1");
    expect_irq(1'b0, "R1");

    // R2 byte lanes, little-endian
    wr(0, 8'h3C); wr(1, 8'h5A); wr(2, 8'hA5);
    expect_rd(0, 8'h3C, "R2"); expect_rd(1, 8'h5A, "R2"); expect_rd(2, 8'hA5, "R2");
    wr(1, 8'h00); wr(2, 8'h00); wr(0, 8'h03);
    expect_rd(0, 8'h03, "R2"); expect_rd(2, 8'h00, "R2");

    // address near a 2^24 boundary
    wr(3, 8'hFE); wr(4, 8'hFF); wr(5, 8'hFF); wr(6, 8'h00);

    // R3 one step
    pulse();
    expect_rd(0, 8'h02, "R3"); expect_rd(3, 8'hFF, "R3"); expect_rd(8, 8'h00, "R3");

    // R9 wrap of low 24 bits
    pulse();
    expect_rd(0, 8'h01, "R3"); expect_rd(3, 8'h00, "R9");
    expect_rd(6, 8'h01, "R9"); expect_rd(8, 8'h02, "R9");

    // R4 done
    pulse();
    expect_rd(0, 8'h00, "R4"); expect_rd(3, 8'h01, "R3"); expect_rd(8, 8'h03, "R4");

    // R5 overrun, no motion
    pulse();
    expect_rd(0, 8'h00, "R5"); expect_rd(3, 8'h01, "R5");
    expect_rd(6, 8'h01, "R5"); expect_rd(8, 8'h07, "R5");

    // R8 / R7 interrupt gating and write-one-to-clear
    expect_irq(1'b0, "R8");
    wr(9, 8'h04);
    expect_irq(1'b1, "R8"); expect_rd(9, 8'h04, "R8");
    wr(8, 8'h04);
    expect_rd(8, 8'h03, "R7"); expect_irq(1'b0, "R8");
    wr(8, 8'h00);
    expect_rd(8, 8'h03, "R7");
    wr(9, 8'h01);
    expect_irq(1'b1, "R8");
    wr(8, 8'h03);
    expect_rd(8, 8'h00, "R7"); expect_irq(1'b0, "R8");

    // R6 control clear
    wr(0, 8'h05);
    expect_rd(0, 8'h05, "R6");
    wr(7, 8'h01);
    expect_rd(0, 8'h00, "R6"); expect_rd(7, 8'h00, "R6"); expect_rd(8, 8'h00, "R6");

    // R10 write beats a same-cycle strobe
    wr(0, 8'h05);
    wr(3, 8'h10, 1);
    expect_rd(0, 8'h05, "R10"); expect_rd(3, 8'h10, "R10");
    expect_rd(6, 8'h01, "R10"); expect_rd(8, 8'h00, "R10");
    wr(7, 8'h01, 1);
    expect_rd(0, 8'h00, "R10"); expect_rd(8, 8'h00, "R10");

    // R11 done event and clear of done in the same cycle
    wr(0, 8'h01);
    wr(8, 8'h01, 1);
    expect_rd(8, 8'h01, "R11"); expect_rd(0, 8'h00, "R11");
    expect_rd(3, 8'h11, "R11"); expect_irq(1'b1, "R11");

    repeat (2) @(negedge clk_i);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule